// File: doc/BRIEF.md
# Two-wire switch management master

This block is the master side of a two-wire serial management bus, a clock line plus one bidirectional data line, used to read and write 16-bit registers inside an Ethernet switch device. A host on the chip issues a one-cycle request that carries a read/write select, a 16-bit register address and, for writes, 16 bits of data. The block then runs one complete frame on the bus. During that frame it holds a busy flag. At the end it gives a one-cycle done pulse, and for a read it presents the assembled 16-bit value at the same time.

Each frame starts with a short three-bit start pattern. A full command byte follows. Its value is a parameter, with one value for reads and another for writes. The address is sent next as two bytes, low byte first. On a read the master then releases the data line and clocks in two bytes from the device, low byte first. On a write it keeps driving the line and sends the two data bytes, low byte first. In both cases it drives a two-bit stop pattern and then gives one more clock pulse with the line released. The length of a bit is set by a divider of the system clock. The bus clock rests low and the data line rests released between frames.

Top module: `mgmt2w_master`

## Requirements
- R1: After reset and between frames, bus_clk is 0, bus_doe is 0, and both busy and done are 0.
- R2: The first three clocked bits of every frame are 1, 0, 1, each driven (bus_doe=1). No clocked bit comes before them.
- R3: Bits 3..10 of the frame carry the command byte, MSB first and driven. The byte is RD_CMD (default 0xA9) for a read (req_write=0) and WR_CMD (default 0xA8) for a write (req_write=1).
- R4: Bits 11..26 carry req_addr as its low byte and then its high byte, each byte MSB first, all driven.
- R5: On a read, bus_doe is 0 for bits 27..42. bus_din is sampled on the system edge that raises bus_clk. The first 8 sampled bits (MSB first) form rd_data[7:0] and the next 8 form rd_data[15:8].
- R6: On a write, bits 27..42 carry req_wdata as its low byte and then its high byte, each MSB first, all driven.
- R7: Bits 43 and 44 are 0 and then 1, both driven. Bit 45 is one more clock pulse with bus_doe=0. A frame has exactly 46 bus_clk pulses.
- R8: Every bit period lasts 2*HALF_DIV system clocks, of which bus_clk is high for HALF_DIV. bus_dout and bus_doe change only while bus_clk is low.
- R9: busy is 1 from the cycle after a request is accepted until the done cycle. A req_valid presented while busy is 1 starts no frame and does not change the frame in progress.
- R10: done is a one-cycle pulse in the first cycle that busy is 0 again, and it carries valid rd_data for a read. A request presented in that done cycle is accepted and starts the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| bus_clk | output | 1 | Management bus clock |
| bus_dout | output | 1 | Data value driven onto the bus |
| bus_doe | output | 1 | Data output enable (1 = drive) |
| bus_din | input | 1 | Data value read from the bus |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. The done pulse and a new request strobe coincide, and this must start a fresh frame. A strobe one cycle earlier, on the edge where the trailing clock finishes, must be dropped. The bench provokes both cases. It raises req_valid exactly in the done cycle of a read and chains a write behind it, and it places a stray strobe on the final busy edge. The chained frame is judged bit by bit against its own expected start, command, address and data fields. After the frame with the stray strobe, the idle window is watched for any further bus clock pulse.

// File: rtl/mgmt2w_pkg.sv
package mgmt2w_pkg;

  localparam int unsigned HDR_BITS   = 3;
  localparam int unsigned CMD_BITS   = 8;
  localparam int unsigned WORD_BITS  = 16;
  localparam int unsigned STOP_BITS  = 2;
  localparam int unsigned TAIL_BITS  = 1;
  localparam int unsigned FRAME_BITS = HDR_BITS + CMD_BITS + 2 * WORD_BITS
                                     + STOP_BITS + TAIL_BITS;
  localparam int unsigned DATA_FIRST = HDR_BITS + CMD_BITS + WORD_BITS;
  localparam int unsigned DATA_LAST  = DATA_FIRST + WORD_BITS - 1;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  localparam logic [HDR_BITS-1:0]  START_PAT = 3'b101;
  localparam logic [STOP_BITS-1:0] STOP_PAT  = 2'b01;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic                 wr;
    logic [WORD_BITS-1:0] addr;
    logic [WORD_BITS-1:0] wdata;
  } xfer_t;

  // Reorder bytes so the least significant byte comes out first when the
  // word is serialised MSB first.
  function automatic logic [WORD_BITS-1:0] lsbyte_first(input logic [WORD_BITS-1:0] w);
    logic [WORD_BITS-1:0] r;
    r = '0;
    for (int b = 0; b < int'(WORD_BITS / 8); b++) begin
      r[WORD_BITS-1-8*b -: 8] = w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/mgmt2w_rst_sync.sv
module mgmt2w_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/mgmt2w_divider.sv
module mgmt2w_divider #(
  parameter int unsigned HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mgmt2w_frame.sv
module mgmt2w_frame
  import mgmt2w_pkg::*;
#(
  parameter logic [CMD_BITS-1:0] RD_CMD = 8'hA9,
  parameter logic [CMD_BITS-1:0] WR_CMD = 8'hA8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  xfer_t                xfer,
  input  logic                 advance,
  input  logic                 capture,
  input  logic                 commit,
  input  logic                 rx_bit,
  output logic                 bit_out,
  output logic                 bit_oe,
  output logic [WORD_BITS-1:0] rd_word
);

  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [FRAME_BITS-1:0] oe_q, oe_d;
  logic [WORD_BITS-1:0]  rx_q, rx_d;
  logic [WORD_BITS-1:0]  hold_q, hold_d;
  logic [CMD_BITS-1:0]   cmd_sel;
  logic [WORD_BITS-1:0]  payload;

  always_comb begin
    cmd_sel = xfer.wr ? WR_CMD : RD_CMD;
    payload = xfer.wr ? lsbyte_first(xfer.wdata) : {WORD_BITS{1'b0}};

    tx_d = tx_q;
    oe_d = oe_q;
    if (load) begin
      tx_d = {START_PAT, cmd_sel, lsbyte_first(xfer.addr), payload,
              STOP_PAT, {TAIL_BITS{1'b0}}};
      oe_d = {{DATA_FIRST{1'b1}}, {WORD_BITS{xfer.wr}},
              {STOP_BITS{1'b1}}, {TAIL_BITS{1'b0}}};
    end else if (advance) begin
      tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
      oe_d = {oe_q[FRAME_BITS-2:0], 1'b0};
    end

    rx_d = rx_q;
    if (capture) begin
      rx_d = {rx_q[WORD_BITS-2:0], rx_bit};
    end

    hold_d = hold_q;
    if (commit) begin
      hold_d = lsbyte_first(rx_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      oe_q   <= '0;
      rx_q   <= '0;
      hold_q <= '0;
    end else begin
      tx_q   <= tx_d;
      oe_q   <= oe_d;
      rx_q   <= rx_d;
      hold_q <= hold_d;
    end
  end

  assign bit_out = tx_q[FRAME_BITS-1];
  assign bit_oe  = oe_q[FRAME_BITS-1];
  assign rd_word = hold_q;

endmodule

// File: rtl/mgmt2w_seq.sv
module mgmt2w_seq
  import mgmt2w_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic tick,
  output logic run,
  output logic load,
  output logic advance,
  output logic capture,
  output logic commit,
  output logic busy,
  output logic done,
  output logic bus_clk
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_RD0  = IDX_W'(DATA_FIRST);
  localparam logic [IDX_W-1:0] IDX_RDN  = IDX_W'(DATA_LAST);

  phase_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wr_q, wr_d;
  logic             finish;
  logic             in_window;
  logic             busy_q, done_q, clk_q;

  always_comb begin
    in_window = (idx_q >= IDX_RD0) && (idx_q <= IDX_RDN);
    state_d   = state_q;
    idx_d     = idx_q;
    wr_d      = wr_q;
    load      = 1'b0;
    advance   = 1'b0;
    capture   = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          state_d = PH_LOW;
          idx_d   = '0;
          wr_d    = req_write;
          load    = 1'b1;
        end
      end
      PH_LOW: begin
        if (tick) begin
          state_d = PH_HIGH;
          capture = in_window && !wr_q;
        end
      end
      PH_HIGH: begin
        if (tick) begin
          advance = 1'b1;
          if (idx_q == IDX_LAST) begin
            state_d = PH_IDLE;
            finish  = 1'b1;
          end else begin
            state_d = PH_LOW;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      busy_q  <= (state_d != PH_IDLE);
      done_q  <= finish;
      clk_q   <= (state_d == PH_HIGH);
    end
  end

  assign run     = (state_q != PH_IDLE);
  assign commit  = finish && !wr_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign bus_clk = clk_q;

endmodule

// File: rtl/mgmt2w_master.sv
module mgmt2w_master
  import mgmt2w_pkg::*;
#(
  parameter int unsigned         HALF_DIV = 25,
  parameter logic [CMD_BITS-1:0] RD_CMD   = 8'hA9,
  parameter logic [CMD_BITS-1:0] WR_CMD   = 8'hA8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        bus_clk,
  output logic        bus_dout,
  output logic        bus_doe,
  input  logic        bus_din
);

  logic  rst_sync_n;
  logic  tick, run, load, advance, capture, commit;
  xfer_t xfer;

  assign xfer = '{wr: req_write, addr: req_addr, wdata: req_wdata};

  mgmt2w_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mgmt2w_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  mgmt2w_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .advance   (advance),
    .capture   (capture),
    .commit    (commit),
    .busy      (busy),
    .done      (done),
    .bus_clk   (bus_clk)
  );

  mgmt2w_frame #(.RD_CMD(RD_CMD), .WR_CMD(WR_CMD)) u_frame (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .xfer    (xfer),
    .advance (advance),
    .capture (capture),
    .commit  (commit),
    .rx_bit  (bus_din),
    .bit_out (bus_dout),
    .bit_oe  (bus_doe),
    .rd_word (rd_data)
  );

endmodule

// File: rtl/mgmt2w_chk.sv
module mgmt2w_chk #(
  parameter int unsigned HALF_DIV = 25
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic bus_clk,
  input logic bus_dout,
  input logic bus_doe
);

  int unsigned hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= 0;
    end else if (bus_clk) begin
      hi_run_q <= hi_run_q + 1;
    end else begin
      hi_run_q <= 0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_clk && !bus_doe));

  p_hold_while_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> ($stable(bus_dout) && $stable(bus_doe)));

  p_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |-> (hi_run_q < HALF_DIV));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind mgmt2w_master mgmt2w_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .bus_clk   (bus_clk),
  .bus_dout  (bus_dout),
  .bus_doe   (bus_doe)
);

// File: tb/sim_mgmt2w_master.sv
module sim_mgmt2w_master;

  localparam int          HALF = 2;
  localparam int          NB   = 46;
  localparam logic [7:0]  RDC  = 8'hA9;
  localparam logic [7:0]  WRC  = 8'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, bus_clk, bus_dout, bus_doe;
  logic [15:0] rd_data;
  logic        bus_din = 1'b1;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  mgmt2w_master #(.HALF_DIV(HALF), .RD_CMD(RDC), .WR_CMD(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_clk(bus_clk), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic slave_bit(input int i, input bit wr, input logic [15:0] v);
    int j;
    if (!wr && i >= 27 && i <= 42) begin
      j = i - 27;
      return (j < 8) ? v[7 - j] : v[15 - (j - 8)];
    end
    return 1'b1;
  endfunction

  // One frame: issue (unless already issued), watch the bus, play the device.
  task automatic run_txn(input bit wr, input logic [15:0] addr,
                         input logic [15:0] wdata, input logic [15:0] rdval,
                         input bit pre, input int spur, input bit chain,
                         input bit nwr, input logic [15:0] naddr,
                         input logic [15:0] nwdata);
    logic [NB-1:0] gb, go, eb, eo;
    logic [7:0]    cmd;
    logic [15:0]   got_rd;
    int idx, k, last_rise, per_bad, hi_cyc, busy_bad, chg_bad, idle_bad;
    bit prev_clk, prev_dout, prev_oe, got_done, done_busy;
    gb = '0; go = '0;
    idx = 0; k = 0; last_rise = 0; per_bad = 0; hi_cyc = 0;
    busy_bad = 0; chg_bad = 0; idle_bad = 0;
    prev_clk = 1'b0; prev_dout = 1'b0; prev_oe = 1'b0;
    got_done = 1'b0; done_busy = 1'b0; got_rd = '0;
    if (!pre) begin
      req_write = wr; req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    end
    while (!got_done && k < NB * 2 * HALF + 40) begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (spur > 0 && k == spur) begin
        req_valid = 1'b1; req_write = !wr; req_addr = ~addr; req_wdata = ~wdata;
      end
      if (spur > 0 && k == spur + 1) req_valid = 1'b0;
      if (done) begin
        got_done  = 1'b1;
        done_busy = busy;
        got_rd    = rd_data;
      end else begin
        if (!busy) busy_bad++;
        if (bus_clk) hi_cyc++;
        if (bus_clk && !prev_clk) begin
          if (idx < NB) begin
            gb[NB-1-idx] = bus_dout;
            go[NB-1-idx] = bus_doe;
          end
          if (idx > 0 && (k - last_rise) != 2 * HALF) per_bad++;
          last_rise = k;
          idx++;
        end
        if (bus_clk && prev_clk && (bus_dout !== prev_dout || bus_doe !== prev_oe)) chg_bad++;
        if (!bus_clk) bus_din = slave_bit(idx, wr, rdval);
        prev_clk = bus_clk; prev_dout = bus_dout; prev_oe = bus_doe;
      end
    end
    if (chain) begin
      req_write = nwr; req_addr = naddr; req_wdata = nwdata; req_valid = 1'b1;
    end else begin
      for (int w = 0; w < 4 * HALF + 4; w++) begin
        @(negedge clk);
        if (bus_clk || bus_doe || busy || done) idle_bad++;
      end
    end
    cmd = wr ? WRC : RDC;
    eb = {3'b101, cmd, addr[7:0], addr[15:8], wdata[7:0], wdata[15:8], 2'b01, 1'b0};
    eo = {{27{1'b1}}, {16{wr}}, 3'b110};
    chk(got_done && !done_busy, "R10", "done seen with busy low", {46'(0), got_done, done_busy}, 48'h2);
    chk(gb[45:43] == 3'b101 && go[45:43] == 3'b111, "R2", "start bits/oe",
        {gb[45:43], go[45:43]}, {eb[45:43], eo[45:43]});
    chk(gb[42:35] == cmd && go[42:35] == 8'hFF, "R3", "command byte", gb[42:35], cmd);
    chk(gb[34:19] == eb[34:19] && go[34:19] == 16'hFFFF, "R4", "address bytes",
        {gb[34:19], go[34:19]}, {eb[34:19], eo[34:19]});
    if (wr) begin
      chk(gb[18:3] == eb[18:3] && go[18:3] == 16'hFFFF, "R6", "write data bytes",
          {gb[18:3], go[18:3]}, {eb[18:3], eo[18:3]});
    end else begin
      chk(go[18:3] == 16'h0000, "R5", "released during read", go[18:3], 16'h0);
      chk(got_rd == rdval, "R5", "read data assembly", got_rd, rdval);
    end
    chk(gb[2:1] == 2'b01 && go[2:0] == 3'b110 && idx == NB, "R7", "stop, tail, pulse count",
        {gb[2:1], go[2:0], 8'(idx)}, {2'b01, 3'b110, 8'(NB)});
    chk(per_bad == 0 && chg_bad == 0 && hi_cyc == NB * HALF, "R8", "bit timing",
        {16'(per_bad), 16'(chg_bad), 16'(hi_cyc)}, {16'd0, 16'd0, 16'(NB * HALF)});
    chk(busy_bad == 0, "R9", "busy held through frame", 48'(busy_bad), 48'd0);
    if (!chain) begin
      chk(idle_bad == 0, "R9", "no frame from ignored request, idle after done (R1, R10)",
          48'(idle_bad), 48'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_clk && !bus_doe && !busy && !done, "R1", "state in reset",
        {44'd0, bus_clk, bus_doe, busy, done}, 48'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!bus_clk && !bus_doe && !busy && !done, "R1", "idle after reset",
        {44'd0, bus_clk, bus_doe, busy, done}, 48'd0);

    for (int i = 0; i <= 16; i++) begin
      logic [15:0] a, d;
      a = (i == 16) ? 16'hFFFF : (16'h0001 << i);
      d = ~a ^ 16'(i * 37);
      run_txn(1'b0, a, 16'h0000, d, 1'b0, (i % 3 == 0) ? 7 : 0, 1'b0, 1'b0, '0, '0);
      run_txn(1'b1, ~a, d, 16'h0000, 1'b0, (i % 4 == 1) ? 50 : 0, 1'b0, 1'b0, '0, '0);
    end
    run_txn(1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 0, 1'b0, 1'b0, '0, '0);
    run_txn(1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, 0, 1'b0, 1'b0, '0, '0);
    // R9: stray strobe on the final busy edge must be dropped.
    run_txn(1'b0, 16'h3C5A, 16'h0000, 16'h8001, 1'b0, NB * 2 * HALF, 1'b0, 1'b0, '0, '0);
    // R10: request in the done cycle starts the next frame (read then write, write then read).
    run_txn(1'b0, 16'h1234, 16'h0000, 16'hBEEF, 1'b0, 0, 1'b1, 1'b1, 16'hA5C3, 16'h0F0F);
    run_txn(1'b1, 16'hA5C3, 16'h0F0F, 16'h0000, 1'b1, 0, 1'b1, 1'b0, 16'h00FF, 16'h0000);
    run_txn(1'b0, 16'h00FF, 16'h0000, 16'h7E81, 1'b1, 0, 1'b0, 1'b0, '0, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule